// File: doc/BRIEF.md
# I2C Target Address Matcher with Bit Mask

This block sits behind a bit-level I2C receiver in a target (slave) device. After every START or repeated START it collects the eight bits of the address phase, most significant bit first. It then decides whether that byte selects this device. The lowest received bit is the read/write direction. It is passed on and never compared.

The comparison works under a mask. Where a mask bit is 1, the received bit must equal the programmed address bit. Where it is 0, that address bit is don't-care. In 10-bit addressing mode only the first address byte is examined: the five fixed prefix bits must be present, and just the two top bits of the 10-bit address are compared against the programmed value under the mask. Address and mask come in through simple write ports. The values in force are latched at each START, so a write made in the middle of a byte only applies from the next START. A hit raises a one-cycle match pulse and an ACK request that stays up until the ninth clock strobe. A START or STOP in the middle of the byte cancels the capture.

Top module: `i2c_addr_match`

## Requirements
- R1: A write to the address register stores write bits 7:1 and forces bit 0 to 0; the stored value is visible on `cfg_addr_o` from the cycle after the write. The reset value is 0x00.
- R2: A write to the mask register stores write bits 7:1 and forces bit 0 to 0; the stored value is visible on `cfg_mask_o` from the cycle after the write. The reset value is 0x00.
- R3: In 7-bit mode (`tenbit_i`=0), a received byte `rx` (first bit = rx[7]) matches when ((rx[7:1] XOR addr[7:1]) AND mask[7:1]) is 0.
- R4: rx[0] is the read/write bit (1 = read). It never affects the match decision, and it is reported on `rw_o` together with the match pulse.
- R5: In 10-bit mode (`tenbit_i`=1), a match requires rx[7:3] = 5'b11110 and ((rx[2:1] XOR addr[2:1]) AND mask[2:1]) = 0. Address and mask bits 7:3 are ignored.
- R6: Take the bit strobe that carries the eighth bit after a START as cycle k. `match_o` is high for exactly cycle k+2. `ack_o` rises in that same cycle and stays high until the cycle after the next bit strobe, START or STOP.
- R7: A STOP during capture abandons the byte, and no further bits are taken until a new START. A START during capture restarts the count from zero. Neither of them produces a match.
- R8: The address and mask used for a byte are those in force at its START. A write during capture applies from the next START. A write in the same cycle as a START applies to that START's byte.
- R9: While reset is applied and right after it, `match_o`, `ack_o` and `rw_o` are 0 and both registers read 0x00.
- R10: Once eight bits have been taken, further bit strobes are ignored until the next START, so a second match cannot occur without a new START.
- R11: A START and a bit strobe in the same cycle: the START wins and that bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen on the bus |
| stop_i | input | 1 | One-cycle pulse: STOP seen on the bus |
| bit_stb_i | input | 1 | One-cycle pulse: SCL rising edge, `bit_i` is valid |
| bit_i | input | 1 | Sampled SDA value |
| tenbit_i | input | 1 | 1 selects 10-bit addressing (first-byte compare) |
| addr_we_i | input | 1 | Address register write enable |
| addr_wdata_i | input | 8 | Address write data, address in bits 7:1 |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 8 | Mask write data, mask in bits 7:1 |
| cfg_addr_o | output | 8 | Stored address register |
| cfg_mask_o | output | 8 | Stored mask register |
| match_o | output | 1 | One-cycle pulse: address phase selected this device |
| ack_o | output | 1 | Request to drive ACK in the ninth clock |
| rw_o | output | 1 | Captured read/write bit of the last complete byte |

## Verification
Two events can land in the same cycle. The first pair is a configuration write and a START. The bench issues an address write in exactly the START cycle, then sends the newly written address, and expects a match. It also writes a new address in the middle of a byte and expects the old address to still decide that byte. The second pair is a START and a bit strobe together. The bench sends them in one cycle and then a full matching byte. It expects a match, which can only happen if the coincident bit was dropped.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned AM_BYTE_W = 8;
  localparam int unsigned AM_PFX_W  = AM_BYTE_W - 3;
  localparam logic [AM_PFX_W-1:0] AM_TEN_PFX = 5'b11110;

  typedef enum logic [1:0] {
    AM_IDLE = 2'd0,
    AM_CAPT = 2'd1,
    AM_DONE = 2'd2
  } am_state_e;
endpackage

// File: rtl/i2c_am_cfg.sv
module i2c_am_cfg #(
  parameter int unsigned BYTE_W = i2c_am_pkg::AM_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_we_i,
  input  logic [BYTE_W-1:0] addr_wdata_i,
  input  logic              mask_we_i,
  input  logic [BYTE_W-1:0] mask_wdata_i,
  output logic [BYTE_W-1:0] cfg_addr_o,
  output logic [BYTE_W-1:0] cfg_mask_o,
  output logic [BYTE_W-1:0] act_addr_o,
  output logic [BYTE_W-1:0] act_mask_o
);
  logic [BYTE_W-1:0] addr_q, addr_d, mask_q, mask_d;
  logic [BYTE_W-1:0] act_addr_q, act_addr_d, act_mask_q, act_mask_d;

  always_comb begin
    addr_d     = addr_q;
    mask_d     = mask_q;
    if (addr_we_i) addr_d = {addr_wdata_i[BYTE_W-1:1], 1'b0};
    if (mask_we_i) mask_d = {mask_wdata_i[BYTE_W-1:1], 1'b0};
    act_addr_d = act_addr_q;
    act_mask_d = act_mask_q;
    if (start_i) begin
      act_addr_d = addr_d;
      act_mask_d = mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      mask_q     <= '0;
      act_addr_q <= '0;
      act_mask_q <= '0;
    end else begin
      addr_q     <= addr_d;
      mask_q     <= mask_d;
      act_addr_q <= act_addr_d;
      act_mask_q <= act_mask_d;
    end
  end

  assign cfg_addr_o = addr_q;
  assign cfg_mask_o = mask_q;
  assign act_addr_o = act_addr_q;
  assign act_mask_o = act_mask_q;

  p_addr_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we_i |=> cfg_addr_o == {$past(addr_wdata_i[BYTE_W-1:1]), 1'b0});
  p_mask_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> cfg_mask_o == {$past(mask_wdata_i[BYTE_W-1:1]), 1'b0});
  p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(act_addr_o) && $stable(act_mask_o)));
  p_active_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (act_addr_o == cfg_addr_o && act_mask_o == cfg_mask_o));
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int unsigned BYTE_W = i2c_am_pkg::AM_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              byte_rdy_o
);
  import i2c_am_pkg::*;
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  am_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rdy_q, rdy_d;
  logic              sh_en;

  assign sh_en = bit_stb_i && (state_q == AM_CAPT) && !start_i && !stop_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rdy_d   = 1'b0;
    if (start_i) begin
      state_d = AM_CAPT;
      cnt_d   = '0;
    end else if (stop_i) begin
      state_d = AM_IDLE;
      cnt_d   = '0;
    end else if (sh_en) begin
      sh_d  = {sh_q[BYTE_W-2:0], bit_i};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) begin
        state_d = AM_DONE;
        rdy_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AM_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rdy_q   <= rdy_d;
    end
  end

  assign rx_byte_o  = sh_q;
  assign byte_rdy_o = rdy_q;

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BYTE_W));
  p_rdy_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rdy_o |=> !byte_rdy_o);
  p_stop_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (state_q == AM_IDLE && !byte_rdy_o));
  p_start_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == AM_CAPT && cnt_q == '0 && !byte_rdy_o));
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
  parameter int unsigned BYTE_W = i2c_am_pkg::AM_BYTE_W
) (
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  logic              tenbit_i,
  output logic              hit_o
);
  import i2c_am_pkg::*;
  localparam int unsigned PFX_LO = BYTE_W - AM_PFX_W;

  logic [BYTE_W-1:0] miss;

  assign miss[0] = 1'b0;

  for (genvar i = 1; i < BYTE_W; i++) begin : g_bit
    logic masked_miss;
    assign masked_miss = (rx_byte_i[i] ^ addr_i[i]) & mask_i[i];
    if (i >= PFX_LO) begin : g_pfx
      assign miss[i] = tenbit_i ? (rx_byte_i[i] != AM_TEN_PFX[i-PFX_LO]) : masked_miss;
    end else begin : g_cmp
      assign miss[i] = masked_miss;
    end
  end

  assign hit_o = ~|miss;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int unsigned BYTE_W = i2c_am_pkg::AM_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  input  logic              tenbit_i,
  input  logic              addr_we_i,
  input  logic [BYTE_W-1:0] addr_wdata_i,
  input  logic              mask_we_i,
  input  logic [BYTE_W-1:0] mask_wdata_i,
  output logic [BYTE_W-1:0] cfg_addr_o,
  output logic [BYTE_W-1:0] cfg_mask_o,
  output logic              match_o,
  output logic              ack_o,
  output logic              rw_o
);
  logic rst_meta_q, rst_sn;
  logic [BYTE_W-1:0] act_addr, act_mask, rx_byte;
  logic byte_rdy, hit, match_hit;
  logic match_q, match_d, ack_q, ack_d, rw_q, rw_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  i2c_am_cfg #(.BYTE_W(BYTE_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_sn),
    .start_i      (start_i),
    .addr_we_i    (addr_we_i),
    .addr_wdata_i (addr_wdata_i),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .cfg_addr_o   (cfg_addr_o),
    .cfg_mask_o   (cfg_mask_o),
    .act_addr_o   (act_addr),
    .act_mask_o   (act_mask)
  );

  i2c_am_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .bit_stb_i  (bit_stb_i),
    .bit_i      (bit_i),
    .rx_byte_o  (rx_byte),
    .byte_rdy_o (byte_rdy)
  );

  i2c_am_cmp #(.BYTE_W(BYTE_W)) u_cmp (
    .rx_byte_i (rx_byte),
    .addr_i    (act_addr),
    .mask_i    (act_mask),
    .tenbit_i  (tenbit_i),
    .hit_o     (hit)
  );

  assign match_hit = byte_rdy && hit && !start_i && !stop_i;

  always_comb begin
    match_d = match_hit;
    ack_d   = ack_q;
    rw_d    = rw_q;
    if (byte_rdy) rw_d = rx_byte[0];
    if (match_hit) ack_d = 1'b1;
    else if (bit_stb_i || start_i || stop_i) ack_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      match_q <= 1'b0;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      match_q <= match_d;
      ack_q   <= ack_d;
      rw_q    <= rw_d;
    end
  end

  assign match_o = match_q;
  assign ack_o   = ack_q;
  assign rw_o    = rw_q;

  p_match_pulse_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    match_o |=> !match_o);
  p_match_ack_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    match_o |-> ack_o);
  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack_o && (bit_stb_i || start_i || stop_i)) |=> !ack_o);
  p_no_match_abort_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_i || stop_i) |=> !match_o);
  p_ack_source_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(ack_o) |-> match_o);
endmodule

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, bit_stb_i = 0, bit_i = 0, tenbit_i = 0;
  logic addr_we_i = 0, mask_we_i = 0;
  logic [7:0] addr_wdata_i = 0, mask_wdata_i = 0;
  logic [7:0] cfg_addr_o, cfg_mask_o;
  logic match_o, ack_o, rw_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_addr = 0, m_mask = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_addr_match uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .bit_stb_i(bit_stb_i), .bit_i(bit_i), .tenbit_i(tenbit_i),
    .addr_we_i(addr_we_i), .addr_wdata_i(addr_wdata_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .cfg_addr_o(cfg_addr_o), .cfg_mask_o(cfg_mask_o),
    .match_o(match_o), .ack_o(ack_o), .rw_o(rw_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_match(input logic [7:0] rx, input logic [7:0] a,
                                     input logic [7:0] m, input logic ten);
    if (ten) return (rx[7:3] == 5'b11110) && (((rx[2:1] ^ a[2:1]) & m[2:1]) == 2'b00);
    return ((rx[7:1] ^ a[7:1]) & m[7:1]) == 7'd0;
  endfunction

  task automatic put_bit(input logic b);
    @(negedge clk); bit_stb_i = 1; bit_i = b;
    @(negedge clk); bit_stb_i = 0;
  endtask

  task automatic put_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic put_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
  endtask

  task automatic wr_addr(input logic [7:0] v);
    @(negedge clk); addr_we_i = 1; addr_wdata_i = v;
    @(negedge clk); addr_we_i = 0;
    m_addr = {v[7:1], 1'b0};
  endtask

  task automatic wr_mask(input logic [7:0] v);
    @(negedge clk); mask_we_i = 1; mask_wdata_i = v;
    @(negedge clk); mask_we_i = 0;
    m_mask = {v[7:1], 1'b0};
  endtask

  task automatic put_bits(input logic [7:0] v, input int from, input int to);
    for (int i = from; i >= to; i--) put_bit(v[i]);
  endtask

  // After the 8th bit task we are one negedge past edge k; result shows after edge k+1.
  task automatic judge(input string req, input logic exp, input logic exp_rw);
    @(negedge clk);
    check({req, " match"}, match_o, exp);
    check({req, " ack"}, ack_o, exp);
    if (exp) check({req, " rw"}, rw_o, exp_rw);
    put_bit(1'b1);
    check({req, " ack released"}, ack_o, 1'b0);
  endtask

  task automatic run_byte(input string req, input logic [7:0] rx);
    logic e;
    e = exp_match(rx, m_addr, m_mask, tenbit_i);
    put_start();
    put_bits(rx, 7, 0);
    judge(req, e, rx[0]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rx;
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: state while reset is held
    check("R9 match in reset", match_o, 0);
    check("R9 ack in reset", ack_o, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R9 match after reset", match_o, 0);
    check("R9 ack after reset", ack_o, 0);
    check("R9 rw after reset", rw_o, 0);
    check("R9 addr reg", cfg_addr_o, 8'h00);
    check("R9 mask reg", cfg_mask_o, 8'h00);

    // R1 / R2: bit 0 forced to 0
    wr_addr(8'hA5);
    check("R1 addr readback", cfg_addr_o, 8'hA4);
    wr_mask(8'hFF);
    check("R2 mask readback", cfg_mask_o, 8'hFE);

    // R3: exact, mismatch, masked don't-care
    wr_addr(8'h50);
    run_byte("R3 exact", 8'h50);
    run_byte("R3 mismatch", 8'h52);
    wr_mask(8'hF0);
    run_byte("R3 masked dontcare", 8'h5E);
    run_byte("R3 masked mismatch", 8'h70);
    wr_mask(8'hFE);

    // R4: rw bit never compared, reported
    run_byte("R4 read", 8'h51);
    run_byte("R4 write", 8'h50);

    // R5: 10-bit mode
    tenbit_i = 1;
    wr_addr(8'h04);               // addr[2:1] = 2'b10
    run_byte("R5 prefix ok", 8'hF5);
    run_byte("R5 low bits differ", 8'hF3);
    run_byte("R5 bad prefix", 8'hE5);
    wr_mask(8'h00);
    run_byte("R5 masked", 8'hF3);
    run_byte("R5 masked bad prefix", 8'h73);
    wr_mask(8'hFE);
    tenbit_i = 0;

    // R6: timing of match and ack
    wr_addr(8'h50);
    put_start();
    put_bits(8'h51, 7, 0);
    check("R6 no match at k+1", match_o, 0);
    @(negedge clk);
    check("R6 match at k+2", match_o, 1);
    check("R6 ack at k+2", ack_o, 1);
    check("R6 rw", rw_o, 1);
    @(negedge clk);
    check("R6 match one cycle", match_o, 0);
    check("R6 ack held", ack_o, 1);
    put_bit(1'b0);
    check("R6 ack drops on ninth strobe", ack_o, 0);

    // R7: STOP mid-byte aborts
    put_start();
    put_bits(8'h50, 7, 4);
    put_stop();
    put_bits(8'h50, 3, 0);
    @(negedge clk);
    check("R7 stop abort match", match_o, 0);
    check("R7 stop abort ack", ack_o, 0);
    // R7: START mid-byte restarts
    put_start();
    put_bits(8'hFF, 7, 5);
    put_start();
    put_bits(8'h50, 7, 0);
    judge("R7 restart", 1'b1, 1'b0);

    // R10: bits after the byte are ignored
    put_bits(8'h50, 7, 0);
    @(negedge clk);
    check("R10 no second match", match_o, 0);
    repeat (2) @(negedge clk);
    check("R10 no ack", ack_o, 0);

    // R8: write during capture applies next START
    put_start();
    put_bits(8'h50, 7, 5);
    wr_addr(8'h60);
    check("R8 register updated", cfg_addr_o, 8'h60);
    put_bits(8'h50, 4, 0);
    judge("R8 old addr decides", 1'b1, 1'b0);
    run_byte("R8 new addr next start", 8'h60);
    // R8: write coincident with START
    @(negedge clk); start_i = 1; addr_we_i = 1; addr_wdata_i = 8'h71;
    @(negedge clk); start_i = 0; addr_we_i = 0;
    m_addr = 8'h70;
    put_bits(8'h70, 7, 0);
    judge("R8 write with start", 1'b1, 1'b0);

    // R11: START with a bit strobe drops the bit
    wr_addr(8'h50);
    @(negedge clk); start_i = 1; bit_stb_i = 1; bit_i = 1;
    @(negedge clk); start_i = 0; bit_stb_i = 0;
    put_bits(8'h50, 7, 0);
    judge("R11 start beats strobe", 1'b1, 1'b0);

    // Random mix, R3 R4 R5
    for (int it = 0; it < 250; it++) begin
      r = $urandom;
      if (r[3:0] == 4'd0) wr_addr($urandom);
      if (r[7:4] == 4'd0) wr_mask($urandom);
      tenbit_i = r[8];
      rx = $urandom;
      if (r[9]) begin
        if (tenbit_i) rx = {5'b11110, m_addr[2:1] ^ (rx[2:1] & ~m_mask[2:1]), rx[0]};
        else rx = {m_addr[7:1] ^ (rx[7:1] & ~m_mask[7:1]), rx[0]};
      end
      run_byte(tenbit_i ? "R5 random" : "R3 R4 random", rx);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule